// File: doc/BRIEF.md
# Three-Lane Block FIR Filter

This block is a 3-tap FIR filter that computes three output samples per core update. A serial input stream arrives one sample per clock with a valid strobe. A serial-to-parallel stage gathers three consecutive samples into a block. On the clock that accepts the third sample of a block, the parallel core computes all three outputs of that block at once. A parallel-to-serial stage then sends the results out one per clock, in order. For each serial sample the core needs only one third of a full filter evaluation per clock. The sample rate can therefore reach three times the rate at which the core itself updates.

The three lanes are not independent copies of one filter. Each lane multiplies a different combination of current and past samples by the taps `a`, `b` and `c`. The two oldest samples that a block needs come from two delay registers. These registers carry the last two samples of the previous block across the block boundary. Each lane has one multiplier and two adders in its path, the same as a serial filter.

All logic runs on one clock. A modulo-3 phase counter, which advances only on accepted samples, acts as the 1-in-3 enable for the core. The taps are static inputs, held constant while a stream is running.

Top module: `tri_fir`

## Requirements
- R1: While reset is asserted and after it is released, the phase counter and both cross-block delay registers are zero and `out_valid` is low. The first block after reset therefore uses x(-1) = x(-2) = 0. A reset in the middle of a block discards the samples already gathered.
- R2: The first result of each block is y(3k) = a·x(3k) + b·x(3k-1) + c·x(3k-2).
- R3: The second result of each block is y(3k+1) = a·x(3k+1) + b·x(3k) + c·x(3k-1).
- R4: The third result of each block is y(3k+2) = a·x(3k+2) + b·x(3k+1) + c·x(3k).
- R5: Only a cycle with `in_valid` high accepts a sample and advances the phase. The first accepted sample after reset is x(0). The value on `in_data` while `in_valid` is low has no effect.
- R6: Each block produces exactly three results. They leave in the order y(3k), y(3k+1), y(3k+2), one per clock, with `out_valid` high in three consecutive cycles.
- R7: `out_valid` for y(3k) first goes high two rising edges after the edge that accepts x(3k+2).
- R8: A block that is still incomplete produces no output. Once later samples complete it, its results follow the normal filter sequence.
- R9: Samples and taps are signed two's complement. Results are exact at width DW+CW+2, with no wrap even when every input is at its most negative value.
- R10: The cross-block delay registers change only on the clock that completes a block. They are then loaded with the second and third samples of that block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one serial sample slot per cycle |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, is released synchronously inside the block |
| coef_a | input | CW | Signed tap applied to the newest sample |
| coef_b | input | CW | Signed tap applied to the sample one step older |
| coef_c | input | CW | Signed tap applied to the sample two steps older |
| in_valid | input | 1 | Qualifies `in_data` for this cycle |
| in_data | input | DW | Signed serial input sample |
| out_valid | output | 1 | Qualifies `out_data` for this cycle |
| out_data | output | DW+CW+2 | Signed serial filter result |

## Verification
On every cycle the checker confirms four things. The phase stays in range and holds when no sample arrives. Completing a block leads to a result strobe one cycle later and to `out_valid` one cycle after that. `out_valid` never starts without a preceding result strobe. The delay registers move only on a block-completing cycle. The values of the three lanes, the signed full-precision arithmetic, and ignoring `in_data` during gaps are shown only by the bench, which compares against a serial convolution. The same holds for partial blocks, for a reset in the middle of a block, and for the exact cycle on which output starts.

// File: rtl/tri_fir_pkg.sv
package tri_fir_pkg;
  localparam int LANES = 3;
  typedef logic [1:0] phase_t;
  localparam phase_t PH_FIRST = 2'd0;
  localparam phase_t PH_LAST  = 2'd2;
endpackage

// File: rtl/tri_fir_s2p.sv
module tri_fir_s2p
  import tri_fir_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output phase_t        phase,
  output logic          blk_go,
  output logic [DW-1:0] blk_x [LANES]
);
  phase_t phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (in_valid) begin
      if (phase_q == PH_LAST) phase_d = PH_FIRST;
      else                    phase_d = phase_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) phase_q <= PH_FIRST;
    else         phase_q <= phase_d;
  end

  assign phase  = phase_q;
  assign blk_go = in_valid && (phase_q == PH_LAST);

  // staging registers for the earlier samples of a block; the last
  // sample is taken straight from the input on the completing cycle
  genvar i;
  generate
    for (i = 0; i < LANES - 1; i++) begin : g_stage
      logic [DW-1:0] stage_q;
      logic          stage_en;
      assign stage_en = in_valid && (phase_q == phase_t'(i));
      always_ff @(posedge clk) begin
        if (stage_en) stage_q <= in_data;
      end
      assign blk_x[i] = stage_q;
    end
  endgenerate

  assign blk_x[LANES-1] = in_data;
endmodule

// File: rtl/tri_fir_core.sv
module tri_fir_core
  import tri_fir_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int OW = DW + CW + 2
) (
  input  logic                 clk,
  input  logic                 rst_sn,
  input  logic                 en,
  input  logic [DW-1:0]        x [LANES],
  input  logic [CW-1:0]        ca,
  input  logic [CW-1:0]        cb,
  input  logic [CW-1:0]        cc,
  output logic signed [OW-1:0] y_q [LANES],
  output logic                 res_stb,
  output logic [DW-1:0]        dly1,
  output logic [DW-1:0]        dly2
);
  localparam int PW  = DW + CW;
  localparam int EXT = OW - PW;

  logic [DW-1:0] d1_q, d2_q, d1_d, d2_d;
  logic          stb_q;
  logic signed [DW-1:0] win [LANES+2];

  // window: two carried samples, then the current block
  assign win[0] = $signed(d2_q);
  assign win[1] = $signed(d1_q);
  genvar j;
  generate
    for (j = 0; j < LANES; j++) begin : g_win
      assign win[j+2] = $signed(x[j]);
    end
  endgenerate

  generate
    for (j = 0; j < LANES; j++) begin : g_lane
      logic signed [PW-1:0] pa, pb, pc;
      logic signed [OW-1:0] sum;
      assign pa  = $signed(ca) * win[j+2];
      assign pb  = $signed(cb) * win[j+1];
      assign pc  = $signed(cc) * win[j];
      assign sum = {{EXT{pa[PW-1]}}, pa} + {{EXT{pb[PW-1]}}, pb}
                 + {{EXT{pc[PW-1]}}, pc};
      always_ff @(posedge clk) begin
        if (en) y_q[j] <= sum;
      end
    end
  endgenerate

  always_comb begin
    d1_d = d1_q;
    d2_d = d2_q;
    if (en) begin
      d1_d = x[LANES-1];
      d2_d = x[LANES-2];
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      d1_q  <= '0;
      d2_q  <= '0;
      stb_q <= 1'b0;
    end else begin
      d1_q  <= d1_d;
      d2_q  <= d2_d;
      stb_q <= en;
    end
  end

  assign res_stb = stb_q;
  assign dly1    = d1_q;
  assign dly2    = d2_q;
endmodule

// File: rtl/tri_fir_p2s.sv
module tri_fir_p2s
  import tri_fir_pkg::*;
#(
  parameter int OW = 18
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          load,
  input  logic [OW-1:0] y [LANES],
  output logic          out_valid,
  output logic [OW-1:0] out_data
);
  localparam int CNTW = $clog2(LANES + 1);

  logic [OW-1:0]   held_q [LANES];
  logic [CNTW-1:0] rem_q, rem_d, idx_q, idx_d;

  always_ff @(posedge clk) begin
    if (load) held_q <= y;
  end

  always_comb begin
    rem_d = rem_q;
    idx_d = idx_q;
    if (load) begin
      rem_d = CNTW'(LANES);
      idx_d = '0;
    end else if (rem_q != '0) begin
      rem_d = rem_q - 1'b1;
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rem_q <= '0;
      idx_q <= '0;
    end else begin
      rem_q <= rem_d;
      idx_q <= idx_d;
    end
  end

  assign out_valid = (rem_q != '0);
  assign out_data  = held_q[idx_q];
endmodule

// File: rtl/tri_fir.sv
module tri_fir
  import tri_fir_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8,
  localparam int OW = DW + CW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] coef_a,
  input  logic [CW-1:0] coef_b,
  input  logic [CW-1:0] coef_c,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [OW-1:0] out_data
);
  logic [1:0]           rs_q;
  logic                 rst_sn;
  phase_t               phase;
  logic                 blk_go, res_stb;
  logic [DW-1:0]        blk_x [LANES];
  logic signed [OW-1:0] lane_y [LANES];
  logic [OW-1:0]        lane_u [LANES];
  logic [DW-1:0]        dly1, dly2;

  // reset: asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  tri_fir_s2p #(.DW(DW)) s2p_i (
    .clk(clk), .rst_sn(rst_sn), .in_valid(in_valid), .in_data(in_data),
    .phase(phase), .blk_go(blk_go), .blk_x(blk_x)
  );

  tri_fir_core #(.DW(DW), .CW(CW), .OW(OW)) core_i (
    .clk(clk), .rst_sn(rst_sn), .en(blk_go), .x(blk_x),
    .ca(coef_a), .cb(coef_b), .cc(coef_c),
    .y_q(lane_y), .res_stb(res_stb), .dly1(dly1), .dly2(dly2)
  );

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_cast
      assign lane_u[g] = lane_y[g];
    end
  endgenerate

  tri_fir_p2s #(.OW(OW)) p2s_i (
    .clk(clk), .rst_sn(rst_sn), .load(res_stb), .y(lane_u),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/tri_fir_chk.sv
module tri_fir_chk
  import tri_fir_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_sn,
  input logic          in_valid,
  input phase_t        phase,
  input logic          blk_go,
  input logic          res_stb,
  input logic          out_valid,
  input logic [DW-1:0] dly1,
  input logic [DW-1:0] dly2
);
  // R5
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    phase <= PH_LAST);

  // R5
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !in_valid |=> $stable(phase));

  // R7
  blk_to_res_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (in_valid && phase == PH_LAST) |=> res_stb);

  // R7
  res_to_out_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    res_stb |=> out_valid);

  // R8
  res_origin_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    res_stb |-> $past(blk_go));

  // R6
  out_start_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(out_valid) |-> $past(res_stb));

  // R10
  dly_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !blk_go |=> ($stable(dly1) && $stable(dly2)));
endmodule

bind tri_fir tri_fir_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_sn(rst_sn), .in_valid(in_valid), .phase(phase),
  .blk_go(blk_go), .res_stb(res_stb), .out_valid(out_valid),
  .dly1(dly1), .dly2(dly2)
);

// File: tb/tri_fir_tb_top.sv
`timescale 1ns/1ps
module tri_fir_tb_top;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int OW = DW + CW + 2;
  localparam int NV = 30;

  // stimulus table: {sample, idle cycles inserted before it}
  localparam int STIM [NV][2] = '{
    '{  12, 0}, '{  -7, 0}, '{  33, 0}, '{ 100, 1}, '{-128, 0},
    '{ 127, 0}, '{   0, 2}, '{   1, 0}, '{  -1, 0}, '{  64, 0},
    '{ -64, 1}, '{  55, 1}, '{  -3, 0}, '{  90, 0}, '{ -90, 3},
    '{  17, 0}, '{  18, 0}, '{  19, 0}, '{-100, 0}, '{  77, 1},
    '{   5, 0}, '{  -2, 0}, '{ 127, 0}, '{ 127, 0}, '{-128, 2},
    '{  42, 0}, '{ -42, 0}, '{   8, 1}, '{  -9, 0}, '{  60, 0}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] coef_a, coef_b, coef_c;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic          out_valid;
  logic [OW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int exp_q [1024];
  int wr = 0, rd = 0, base = 0;
  int h1 = 0, h2 = 0;
  int ca = 0, cb = 0, cc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tri_fir #(.DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .coef_a(coef_a), .coef_b(coef_b),
    .coef_c(coef_c), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // output monitor: every result against the serial convolution (R2 R3 R4 R9)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rd == wr) begin
        check(1'b0, "R6 extra output", $signed(out_data), 0);
      end else begin
        case ((rd - base) % 3)
          0:       check($signed(out_data) == exp_q[rd % 1024], "R2 lane0",
                         $signed(out_data), exp_q[rd % 1024]);
          1:       check($signed(out_data) == exp_q[rd % 1024], "R3 lane1",
                         $signed(out_data), exp_q[rd % 1024]);
          default: check($signed(out_data) == exp_q[rd % 1024], "R4 lane2",
                         $signed(out_data), exp_q[rd % 1024]);
        endcase
        rd++;
      end
    end
  end

  task automatic set_coef(input int a, input int b, input int c);
    ca = a; cb = b; cc = c;
    coef_a = a[CW-1:0]; coef_b = b[CW-1:0]; coef_c = c[CW-1:0];
  endtask

  task automatic send(input int x);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x[DW-1:0];
    exp_q[wr % 1024] = ca * x + cb * h1 + cc * h2;
    h2 = h1;
    h1 = x;
    wr++;
  endtask

  // idle cycles carry junk data that must be ignored (R5)
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 8'hA5;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    h1 = 0; h2 = 0;
    wr = rd;
    base = rd;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after release", out_valid, 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", rd, wr);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    set_coef(3, -5, 7);
    do_reset();

    // table walk: mixed values with gaps (R2 R3 R4 R5 R10)
    for (int i = 0; i < NV; i++) begin
      idle(STIM[i][1]);
      send(STIM[i][0]);
    end
    idle(8);
    check(rd == wr, "R6 all table results emitted", rd, wr);
    check(rd - base == NV, "R10 table result count", rd - base, NV);

    // R7 / R6: exact cadence after the third sample
    do_reset();
    send(9); idle(1); send(-4); send(21);
    @(negedge clk); in_valid = 1'b0;
    check(out_valid == 1'b0, "R7 no output one edge after block", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R7 first result two edges after block", out_valid, 1);
    @(negedge clk);
    check(out_valid == 1'b1, "R6 second result", out_valid, 1);
    @(negedge clk);
    check(out_valid == 1'b1, "R6 third result", out_valid, 1);
    @(negedge clk);
    check(out_valid == 1'b0, "R6 exactly three results", out_valid, 0);

    // R9: extreme values, no wrap
    set_coef(-128, -128, -128);
    do_reset();
    send(-128); send(-128); send(-128);
    send(127); send(127); send(127);
    send(-128); send(127); send(-128);
    idle(8);
    check(rd == wr, "R9 extreme results emitted", rd, wr);

    // R8: partial block held back, then completed
    set_coef(2, 1, -1);
    do_reset();
    send(10); send(20); send(30); send(40); send(50); send(60); send(70);
    idle(10);
    check(rd - base == 6, "R8 partial block yields nothing", rd - base, 6);
    send(80); send(90);
    idle(8);
    check(rd - base == 9, "R8 completed block emitted", rd - base, 9);

    // R1: reset in the middle of a block clears history and phase
    send(111); send(-77);
    do_reset();
    send(5); send(6); send(7);
    idle(8);
    check(rd - base == 3, "R1 fresh block after mid-block reset", rd - base, 3);
    check(rd == wr, "R1 queue drained", rd, wr);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule